// File: doc/BRIEF.md
# Pack, Negated-Logic and Min/Max Unit

This block is one slice of an integer execution datapath whose width is 32 or 64 bits. It takes two operands and a four-bit operation code. It computes one result from three groups of functions:

- logic with an inverted second operand;
- joining fixed slices of the two operands (packing);
- signed and unsigned minimum and maximum, together with byte and half-word sign extension.

The result passes through one output register, and a valid flag travels with it.

An issue stage presents operands, the code and `in_valid` for one cycle. On the next clock edge the registered result, an illegal-code flag and `out_valid` appear. These outputs hold their values until the next valid issue. The 32-bit word packing forms exist only when the datapath is 64 bits wide. At 32 bits their codes are treated as unsupported.

Top module: `bitpack_alu`

## Requirements
- R1: The result, the illegal flag and `out_valid` come from one register stage. A valid issue in cycle N is visible after the edge that ends cycle N, and `out_valid` follows `in_valid` with one cycle of delay. While `in_valid` is low, the result and the illegal flag keep their values.
- R2: Code 0 returns `a AND (NOT b)`.
- R3: Code 1 returns `a OR (NOT b)`. Code 2 returns `NOT (a XOR b)`.
- R4: Code 3 returns the low half of `a` in the low half of the result and the low half of `b` in the upper half. Code 4 returns the upper half of `a` in the low half and the upper half of `b` in the upper half.
- R5: Code 5 returns `a[7:0]` in bits 7:0 and `b[7:0]` in bits 15:8. All bits above 15 are zero.
- R6: On a 64-bit datapath, code 6 forms the 32-bit word `{b[15:0], a[15:0]}` and code 7 forms `{b[31:16], a[31:16]}`. Each word is sign-extended from its bit 31 to 64 bits. On a 32-bit datapath, codes 6 and 7 are unsupported.
- R7: Code 8 returns the signed (two's-complement) minimum of `a` and `b`. Code 9 returns the signed maximum.
- R8: Code 10 returns the unsigned minimum and code 11 the unsigned maximum. When `a` equals `b`, all four min/max codes return that value.
- R9: Code 12 copies bit 7 of `a` into every higher bit. Code 13 copies bit 15 of `a` into every higher bit.
- R10: Codes 14 and 15 (and 6 and 7 on a 32-bit datapath) produce a zero result with the illegal flag set. Every supported code clears the illegal flag.
- R11: During and right after reset, `out_valid`, the result and the illegal flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe for the operands and code |
| in_op | input | 4 | Operation code |
| in_a | input | XLEN | First operand |
| in_b | input | XLEN | Second operand |
| out_valid | output | 1 | Registered result is fresh |
| out_result | output | XLEN | Registered result |
| out_illegal | output | 1 | Registered unsupported-code flag |

## Verification
Every result, the illegal flag and `out_valid` are due exactly one clock edge after the issue cycle. The bench drives inputs just after a falling edge and compares all three outputs at the next falling edge. By then the single register stage has captured the issue, and the inputs for the next issue have not yet been sampled. On idle cycles the reference model keeps its previous result and flag, so every clock compares against a hold. The assertions check the same one-edge relation with `|=>`.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ANDNOT  = 4'd0,
    OP_ORNOT   = 4'd1,
    OP_XNOR    = 4'd2,
    OP_PACKLO  = 4'd3,
    OP_PACKHI  = 4'd4,
    OP_PACKB   = 4'd5,
    OP_PACKWLO = 4'd6,
    OP_PACKWHI = 4'd7,
    OP_MIN     = 4'd8,
    OP_MAX     = 4'd9,
    OP_MINU    = 4'd10,
    OP_MAXU    = 4'd11,
    OP_SEXTB   = 4'd12,
    OP_SEXTH   = 4'd13
  } bp_op_e;
endpackage

// File: rtl/bp_logic.sv
module bp_logic #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] andn_o,
  output logic [XLEN-1:0] orn_o,
  output logic [XLEN-1:0] xnor_o,
  output logic [XLEN-1:0] sextb_o,
  output logic [XLEN-1:0] sexth_o
);
  function automatic logic [XLEN-1:0] f_sext8(input logic [7:0] v);
    return {{(XLEN-8){v[7]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] f_sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  assign andn_o  = a & ~b;
  assign orn_o   = a | ~b;
  assign xnor_o  = ~(a ^ b);
  assign sextb_o = f_sext8(a[7:0]);
  assign sexth_o = f_sext16(a[15:0]);
endmodule

// File: rtl/bp_pack.sv
module bp_pack #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] plo_o,
  output logic [XLEN-1:0] phi_o,
  output logic [XLEN-1:0] pbyte_o,
  output logic [XLEN-1:0] pwlo_o,
  output logic [XLEN-1:0] pwhi_o
);
  localparam int HALF = XLEN / 2;

  function automatic logic [XLEN-1:0] f_join16(input logic [15:0] lo,
                                               input logic [15:0] hi);
    logic [31:0] w;
    w = {hi, lo};
    return {{(XLEN-32){w[31]}}, w};
  endfunction

  assign plo_o   = {b[HALF-1:0], a[HALF-1:0]};
  assign phi_o   = {b[XLEN-1:HALF], a[XLEN-1:HALF]};
  assign pbyte_o = {{(XLEN-16){1'b0}}, b[7:0], a[7:0]};

  generate
    if (XLEN >= 64) begin : g_word
      assign pwlo_o = f_join16(a[15:0], b[15:0]);
      assign pwhi_o = f_join16(a[31:16], b[31:16]);
    end else begin : g_noword
      assign pwlo_o = '0;
      assign pwhi_o = '0;
    end
  endgenerate
endmodule

// File: rtl/bp_minmax.sv
module bp_minmax #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            lt_s_o,
  output logic            lt_u_o,
  output logic [XLEN-1:0] min_o,
  output logic [XLEN-1:0] max_o,
  output logic [XLEN-1:0] minu_o,
  output logic [XLEN-1:0] maxu_o
);
  function automatic logic f_lt_signed(input logic [XLEN-1:0] x,
                                       input logic [XLEN-1:0] y);
    return $signed(x) < $signed(y);
  endfunction

  assign lt_s_o = f_lt_signed(a, b);
  assign lt_u_o = a < b;
  assign min_o  = lt_s_o ? a : b;
  assign max_o  = lt_s_o ? b : a;
  assign minu_o = lt_u_o ? a : b;
  assign maxu_o = lt_u_o ? b : a;
endmodule

// File: rtl/bitpack_alu.sv
module bitpack_alu #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [3:0]      in_op,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic            out_illegal
);
  import bp_pkg::*;

  localparam bit HAS_WORD = (XLEN >= 64);

  bp_op_e op_e;
  assign op_e = bp_op_e'(in_op);

  logic [XLEN-1:0] andn_w, orn_w, xnor_w, sextb_w, sexth_w;
  logic [XLEN-1:0] plo_w, phi_w, pbyte_w, pwlo_w, pwhi_w;
  logic [XLEN-1:0] min_w, max_w, minu_w, maxu_w;
  logic            lt_s_w, lt_u_w;
  logic [XLEN-1:0] nxt_result;
  logic            nxt_illegal;

  bp_logic #(.XLEN(XLEN)) logic_i (
    .a(in_a), .b(in_b), .andn_o(andn_w), .orn_o(orn_w), .xnor_o(xnor_w),
    .sextb_o(sextb_w), .sexth_o(sexth_w)
  );

  bp_pack #(.XLEN(XLEN)) pack_i (
    .a(in_a), .b(in_b), .plo_o(plo_w), .phi_o(phi_w), .pbyte_o(pbyte_w),
    .pwlo_o(pwlo_w), .pwhi_o(pwhi_w)
  );

  bp_minmax #(.XLEN(XLEN)) mm_i (
    .a(in_a), .b(in_b), .lt_s_o(lt_s_w), .lt_u_o(lt_u_w),
    .min_o(min_w), .max_o(max_w), .minu_o(minu_w), .maxu_o(maxu_w)
  );

  always_comb begin
    nxt_illegal = 1'b0;
    nxt_result  = '0;
    case (op_e)
      OP_ANDNOT:  nxt_result = andn_w;
      OP_ORNOT:   nxt_result = orn_w;
      OP_XNOR:    nxt_result = xnor_w;
      OP_PACKLO:  nxt_result = plo_w;
      OP_PACKHI:  nxt_result = phi_w;
      OP_PACKB:   nxt_result = pbyte_w;
      OP_PACKWLO: begin
        if (HAS_WORD) nxt_result = pwlo_w;
        else          nxt_illegal = 1'b1;
      end
      OP_PACKWHI: begin
        if (HAS_WORD) nxt_result = pwhi_w;
        else          nxt_illegal = 1'b1;
      end
      OP_MIN:     nxt_result = min_w;
      OP_MAX:     nxt_result = max_w;
      OP_MINU:    nxt_result = minu_w;
      OP_MAXU:    nxt_result = maxu_w;
      OP_SEXTB:   nxt_result = sextb_w;
      OP_SEXTH:   nxt_result = sexth_w;
      default:    nxt_illegal = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= nxt_result;
        out_illegal <= nxt_illegal;
      end
    end
  end
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [3:0]      in_op,
  input logic [XLEN-1:0] in_a,
  input logic [XLEN-1:0] in_b,
  input logic            out_valid,
  input logic [XLEN-1:0] out_result,
  input logic            out_illegal
);
  logic issue_mm, issue_pb, issue_sb;
  assign issue_mm = in_valid && (in_op >= 4'd8) && (in_op <= 4'd11);
  assign issue_pb = in_valid && (in_op == 4'd5);
  assign issue_sb = in_valid && (in_op == 4'd12);

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_illegal) && !out_valid)); // R1
  AST_PACKB_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    issue_pb |=> (out_result[XLEN-1:16] == '0)); // R5
  AST_MINMAX_PICKS_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    issue_mm |=> (out_result == $past(in_a) || out_result == $past(in_b))); // R8
  AST_SEXTB_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    issue_sb |=> ((&out_result[XLEN-1:7]) || !(|out_result[XLEN-1:7]))); // R9
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_result == '0)); // R10
  AST_HIGH_CODE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[3:1] == 3'b111) |=> out_illegal); // R10
endmodule

bind bitpack_alu bp_checker #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
  .out_result(out_result), .out_illegal(out_illegal)
);

// File: tb/bitpack_alu_tb_top.sv
`timescale 1ns/1ps
module bitpack_alu_tb_top;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [3:0]      in_op = '0;
  logic [XLEN-1:0] in_a = '0;
  logic [XLEN-1:0] in_b = '0;
  logic            out_valid;
  logic [XLEN-1:0] out_result;
  logic            out_illegal;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [XLEN-1:0] m_res = '0;
  logic            m_ill = 1'b0;
  logic            m_val = 1'b0;

  always #2.5 clk = ~clk;

  bitpack_alu #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_result(out_result), .out_illegal(out_illegal)
  );

  function automatic logic [XLEN-1:0] sx(logic [XLEN-1:0] v, int top);
    logic [XLEN-1:0] r = v;
    for (int i = top + 1; i < XLEN; i++) r[i] = v[top];
    return r;
  endfunction

  function automatic logic [XLEN-1:0] ref_op(int op, logic [XLEN-1:0] a,
                                             logic [XLEN-1:0] b, output bit ill);
    int h = XLEN / 2;
    logic [XLEN-1:0] lom = (XLEN'(1) << h) - 1;
    ill = 1'b0;
    case (op)
      0:  return a & ~b;
      1:  return a | ~b;
      2:  return ~(a ^ b);
      3:  return ((b & lom) << h) | (a & lom);
      4:  return (b & ~lom) | (a >> h);
      5:  return ((b & 'hFF) << 8) | (a & 'hFF);
      6:  return sx(((b & 'hFFFF) << 16) | (a & 'hFFFF), 31);
      7:  return sx((b & 'hFFFF_0000) | ((a >> 16) & 'hFFFF), 31);
      8:  return ($signed(a) <= $signed(b)) ? a : b;
      9:  return ($signed(a) >= $signed(b)) ? a : b;
      10: return (a <= b) ? a : b;
      11: return (a >= b) ? a : b;
      12: return sx(a, 7);
      13: return sx(a, 15);
      default: begin ill = 1'b1; return '0; end
    endcase
  endfunction

  task automatic check(string tag);
    n_tests++;
    if (out_valid !== m_val || out_result !== m_res || out_illegal !== m_ill) begin
      n_fail++;
      $display("FAIL %s: got v=%0b r=%h i=%0b expected v=%0b r=%h i=%0b", tag,
               out_valid, out_result, out_illegal, m_val, m_res, m_ill);
    end
  endtask

  task automatic step(bit v, int op, logic [XLEN-1:0] a, logic [XLEN-1:0] b,
                      string tag);
    bit il;
    logic [XLEN-1:0] r;
    in_valid = v; in_op = 4'(op); in_a = a; in_b = b;
    m_val = v;
    if (v) begin
      r = ref_op(op, a, b, il);
      m_res = r; m_ill = il;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R11 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after reset");

    step(1, 0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_00FF_F0F0_FFFF, "R2 andnot");
    step(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R2 andnot zero b");
    step(1, 1, 64'h1234_0000_0000_0001, 64'hFFFF_0000_FFFF_0000, "R3 ornot");
    step(1, 2, 64'hA5A5_A5A5_0000_FFFF, 64'h5A5A_A5A5_FFFF_FFFF, "R3 xnor");
    step(1, 3, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, "R4 pack low");
    step(1, 4, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, "R4 pack high");
    step(1, 5, 64'hFFFF_FFFF_FFFF_FFAB, 64'hFFFF_FFFF_FFFF_FFCD, "R5 pack bytes");
    step(1, 6, 64'h0000_0000_0000_1234, 64'h0000_0000_0000_8765, "R6 word pack neg");
    step(1, 6, 64'hFFFF_FFFF_FFFF_1234, 64'hFFFF_FFFF_FFFF_7765, "R6 word pack pos");
    step(1, 7, 64'h0000_0000_ABCD_0000, 64'h0000_0000_F00D_0000, "R6 word pack upper");
    step(1, 8, 64'hFFFF_FFFF_FFFF_FFFE, 64'h5, "R7 signed min");
    step(1, 9, 64'hFFFF_FFFF_FFFF_FFFE, 64'h5, "R7 signed max");
    step(1, 9, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, "R7 signed max extremes");
    step(1, 10, 64'hFFFF_FFFF_FFFF_FFFE, 64'h5, "R8 unsigned min");
    step(1, 11, 64'hFFFF_FFFF_FFFF_FFFE, 64'h5, "R8 unsigned max");
    step(1, 8, 64'hDEAD_BEEF, 64'hDEAD_BEEF, "R8 equal signed min");
    step(1, 11, 64'hDEAD_BEEF, 64'hDEAD_BEEF, "R8 equal unsigned max");
    step(1, 12, 64'h0000_0000_0000_0080, 64'h0, "R9 sext byte neg");
    step(1, 12, 64'hFFFF_FFFF_FFFF_FF7F, 64'h0, "R9 sext byte pos");
    step(1, 13, 64'h0000_0000_0000_8001, 64'h0, "R9 sext half neg");
    step(1, 14, 64'h1234, 64'h5678, "R10 code 14");
    step(0, 3, 64'h9999, 64'h9999, "R1 idle holds illegal");
    step(1, 15, 64'hFFFF, 64'hFFFF, "R10 code 15");
    step(1, 2, 64'h0, 64'h0, "R10 legal clears flag");
    step(0, 0, 64'h1, 64'h2, "R1 idle holds result");
    step(0, 5, 64'h3, 64'h4, "R1 second idle");
    for (int i = 0; i < 40; i++) begin
      logic [XLEN-1:0] ra = {$urandom, $urandom};
      logic [XLEN-1:0] rb = {$urandom, $urandom};
      step(($urandom % 4) != 0, int'($urandom % 16), ra, rb, "R1 mixed stream");
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule